// File: doc/BRIEF.md
# Watchdog Timer with Grace-Period Reset

This block supervises software through an 18-bit up counter that runs on its own slow watchdog clock. Once enabled, the counter advances on each watchdog clock. When it reaches a programmable power-of-two interval, the block raises a time-out flag and, if enabled, an interrupt and a wake-up request. A second, shorter window then opens. If reset generation is armed and software has not cleared the counter by the end of that window, the block emits a one-cycle reset pulse on the system clock.

Software reaches the block through a small 32-bit register bus on the system clock. There are three registers: control at 0x00, a grace-window select at 0x04, and a kick register at 0x08. The kick register clears the counter only when it is written with a magic key. Most configuration fields accept writes only while an external unlock input is high. A forced-enable input pins the watchdog on. A debug-halt input freezes counting unless software has asked the block to ignore it. Every control value crosses into the watchdog domain through two-flop synchronizers. Time-out and reset events come back as toggles that are turned into single-cycle pulses.

Top module: `wdt_top`

## Requirements
- R1: After reset, control (0x00) and grace select (0x04) read 0, and so do the kick register (0x08) and any other address.
- R2: Time-out select in control bits [10:8] (sel) gives an interval of 2^(4+2*sel) watchdog clocks. When the counter reaches it, the time-out flag (bit 3) sets, and `irq` is high while both that flag and interrupt enable (bit 6) are 1.
- R3: The grace select field, bits [1:0] at 0x04, picks the grace window: 00 gives 1026 watchdog clocks, 01 gives 130, 10 gives 18 and 11 gives 3. With reset enable (bit 1) set and no clear during the window, a reset pulse follows the time-out by that many watchdog clocks.
- R4: A watchdog reset sets the reset flag (bit 2) and returns the grace select to 00. Bits 2, 3 and 5 are each cleared by writing 1 to them, with or without unlock.
- R5: With interrupt enable (bit 6) and wake enable (bit 4) both set, a time-out sets the wake flag (bit 5), and `wake_req` follows that flag.
- R6: Clearing the enable bit (bit 7) resets the counter. Bit 30 reads 1 from an enable change until the watchdog domain has taken it, which takes a few watchdog clocks.
- R7: Writing 0x00005AA5 to 0x08 clears the counter, with or without unlock, and any other value written there has no effect. Writing 1 to control bit 0 under unlock also clears the counter, and bit 0 always reads 0.
- R8: Bits 0, 1, 4, 6, 7, [10:8] and 31 of control, and the grace select, change only on writes made while `unlock` is high.
- R9: While `force_en` is high, control bit 7 reads 1 and the watchdog runs, even after 0 has been written to that bit.
- R10: With the debug-ignore bit (bit 31) at 0, the counter holds while `dbg_halt` is high. With it at 1, the counter keeps running.
- R11: The reset output is exactly one system clock wide. With reset enable at 0, no reset pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (bus) clock |
| wdt_clk | input | 1 | Slow watchdog counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe, one system cycle per write |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| unlock | input | 1 | Permits writes to protected fields |
| force_en | input | 1 | Forces the watchdog on |
| dbg_halt | input | 1 | Debugger halt request |
| irq | output | 1 | Time-out interrupt, level |
| wake_req | output | 1 | Wake-up request, level |
| wdt_rst_o | output | 1 | Watchdog reset, one-cycle pulse |

## Verification
The bench measures the gap between the interrupt edge and the reset pulse, in watchdog clocks, for three grace settings. An off-by-one in the grace comparator, or a wrong encoding, lands outside a two-clock window. It stretches periodic key writes across several intervals and then sends a near-miss key. A design that treated any write as a kick would never time out, and one that ignored the key would fire early. It disables the watchdog close to the time-out and re-enables it. A counter that survived the disable would fire within half an interval. It also checks that locked writes, a forced enable and a debug halt leave the register image and the counting exactly as the requirements state.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W  = 18;
  localparam int GR_W   = 11;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CTL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_GRC = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_KEY = 4'h8;
  localparam logic [31:0]       KICK_KEY = 32'h0000_5AA5;

  // control bit positions (software-visible layout)
  localparam int B_KICK = 0;
  localparam int B_RSTE = 1;
  localparam int B_RSTF = 2;
  localparam int B_TOF  = 3;
  localparam int B_WKE  = 4;
  localparam int B_WKF  = 5;
  localparam int B_IE   = 6;
  localparam int B_EN   = 7;
  localparam int B_TSL  = 8;
  localparam int B_BUSY = 30;
  localparam int B_IGN  = 31;

  // interval in watchdog clocks: 2^(4+2*sel)
  function automatic logic [CNT_W:0] tout_len(input logic [2:0] sel);
    return (CNT_W+1)'(1) << (4 + 2 * int'(sel));
  endfunction

  // grace window in watchdog clocks
  function automatic logic [GR_W-1:0] grace_len(input logic [1:0] dsel);
    case (dsel)
      2'b00:   return GR_W'(1026);
      2'b01:   return GR_W'(130);
      2'b10:   return GR_W'(18);
      default: return GR_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/wdt_sync2.sv
module wdt_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/wdt_evt_xing.sv
module wdt_evt_xing (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst_n,
  input  logic src_evt,
  output logic dst_pulse
);
  logic tgl, tgl_s, tgl_d;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)       tgl <= 1'b0;
    else if (src_evt) tgl <= ~tgl;
  end

  wdt_sync2 #(.W(1)) u_sync (.clk(dst_clk), .rst_n(rst_n), .d(tgl), .q(tgl_s));

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) tgl_d <= 1'b0;
    else        tgl_d <= tgl_s;
  end

  assign dst_pulse = tgl_s ^ tgl_d;
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int GW = GR_W
) (
  input  logic          wdt_clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          kick,
  input  logic          halt,
  input  logic          rsten,
  input  logic [2:0]    tsel,
  input  logic [1:0]    dsel,
  output logic          tout_evt,
  output logic          rst_evt,
  output logic [CW-1:0] cnt_o,
  output logic          grace_o
);
  logic [CW-1:0] cnt;
  logic [GW-1:0] gcnt;
  logic          grace;
  logic [CW:0]   cnt_nxt;
  logic [GW-1:0] gcnt_nxt;
  logic          hit;
  logic          gdone;

  assign cnt_nxt  = {1'b0, cnt} + 1'b1;
  assign gcnt_nxt = gcnt + 1'b1;
  assign hit      = (cnt_nxt >= (CW+1)'(tout_len(tsel)));
  assign gdone    = grace && (gcnt_nxt >= GW'(grace_len(dsel)));

  always_ff @(posedge wdt_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; gcnt <= '0; grace <= 1'b0;
      tout_evt <= 1'b0; rst_evt <= 1'b0;
    end else begin
      tout_evt <= 1'b0;
      rst_evt  <= 1'b0;
      if (!en || kick) begin
        cnt <= '0; gcnt <= '0; grace <= 1'b0;
      end else if (!halt) begin
        if (hit) begin
          cnt      <= '0;
          tout_evt <= 1'b1;
          if (!grace) begin
            grace <= 1'b1;
            gcnt  <= '0;
          end
        end else begin
          cnt <= cnt_nxt[CW-1:0];
        end
        if (grace) begin
          if (gdone) begin
            grace <= 1'b0;
            gcnt  <= '0;
            if (rsten) begin
              rst_evt <= 1'b1;
              cnt     <= '0;
            end
          end else begin
            gcnt <= gcnt_nxt;
          end
        end
      end
    end
  end

  assign cnt_o   = cnt;
  assign grace_o = grace;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              wdt_clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              unlock,
  input  logic              force_en,
  input  logic              dbg_halt,
  output logic              irq,
  output logic              wake_req,
  output logic              wdt_rst_o
);
  localparam int XW = 9;  // en, rsten, halt, tsel[3], dsel[2] + spare

  logic       en_q, rsten_q, wken_q, inten_q, ign_q;
  logic [2:0] tsel_q;
  logic [1:0] dsel_q;
  logic       rstf_q, tof_q, wkf_q;

  logic wr_ctl, wr_grc, wr_key;
  logic kick_req, en_eff, halt_eff, en_back, busy;
  logic tout_p, rst_p;

  assign wr_ctl   = bus_wr && (bus_addr == OFS_CTL);
  assign wr_grc   = bus_wr && (bus_addr == OFS_GRC);
  assign wr_key   = bus_wr && (bus_addr == OFS_KEY);
  assign kick_req = (wr_ctl && unlock && bus_wdata[B_KICK]) ||
                    (wr_key && (bus_wdata == KICK_KEY));
  assign en_eff   = en_q | force_en;
  assign halt_eff = dbg_halt & ~ign_q;

  // system-domain register state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; rsten_q <= 1'b0; wken_q <= 1'b0; inten_q <= 1'b0; ign_q <= 1'b0;
      tsel_q <= '0; dsel_q <= '0;
      rstf_q <= 1'b0; tof_q <= 1'b0; wkf_q <= 1'b0;
      wdt_rst_o <= 1'b0;
    end else begin
      wdt_rst_o <= rst_p;
      if (wr_ctl && unlock) begin
        rsten_q <= bus_wdata[B_RSTE];
        wken_q  <= bus_wdata[B_WKE];
        inten_q <= bus_wdata[B_IE];
        en_q    <= bus_wdata[B_EN];
        tsel_q  <= bus_wdata[B_TSL +: 3];
        ign_q   <= bus_wdata[B_IGN];
      end
      if (wr_ctl && bus_wdata[B_RSTF]) rstf_q <= 1'b0;
      if (wr_ctl && bus_wdata[B_TOF])  tof_q  <= 1'b0;
      if (wr_ctl && bus_wdata[B_WKF])  wkf_q  <= 1'b0;
      if (wr_grc && unlock)            dsel_q <= bus_wdata[1:0];
      if (tout_p) begin
        tof_q <= 1'b1;
        if (inten_q && wken_q) wkf_q <= 1'b1;
      end
      if (rst_p) begin
        rstf_q <= 1'b1;
        dsel_q <= 2'b00;
      end
    end
  end

  // crossing into the watchdog domain
  logic [XW-1:0] x_src, x_dst;
  logic          en_w, rsten_w, halt_w;
  logic [2:0]    tsel_w;
  logic [1:0]    dsel_w;
  logic          kick_w, tout_w, rst_w, grace_w;
  logic [CNT_W-1:0] cnt_w;

  assign x_src = {1'b0, dsel_q, tsel_q, halt_eff, rsten_q, en_eff};
  wdt_sync2 #(.W(XW)) u_cfg_sync (.clk(wdt_clk), .rst_n(rst_n), .d(x_src), .q(x_dst));
  assign en_w    = x_dst[0];
  assign rsten_w = x_dst[1];
  assign halt_w  = x_dst[2];
  assign tsel_w  = x_dst[5:3];
  assign dsel_w  = x_dst[7:6];

  wdt_evt_xing u_kick_x (.src_clk(clk), .dst_clk(wdt_clk), .rst_n(rst_n),
                         .src_evt(kick_req), .dst_pulse(kick_w));

  wdt_core u_core (
    .wdt_clk(wdt_clk), .rst_n(rst_n), .en(en_w), .kick(kick_w), .halt(halt_w),
    .rsten(rsten_w), .tsel(tsel_w), .dsel(dsel_w), .tout_evt(tout_w),
    .rst_evt(rst_w), .cnt_o(cnt_w), .grace_o(grace_w)
  );

  // events back to the system domain
  wdt_evt_xing u_tout_x (.src_clk(wdt_clk), .dst_clk(clk), .rst_n(rst_n),
                         .src_evt(tout_w), .dst_pulse(tout_p));
  wdt_evt_xing u_rst_x  (.src_clk(wdt_clk), .dst_clk(clk), .rst_n(rst_n),
                         .src_evt(rst_w), .dst_pulse(rst_p));
  wdt_sync2 #(.W(1)) u_en_back (.clk(clk), .rst_n(rst_n), .d(en_w), .q(en_back));

  assign busy     = en_eff ^ en_back;
  assign irq      = tof_q & inten_q;
  assign wake_req = wkf_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTL: begin
        bus_rdata[B_RSTE]     = rsten_q;
        bus_rdata[B_RSTF]     = rstf_q;
        bus_rdata[B_TOF]      = tof_q;
        bus_rdata[B_WKE]      = wken_q;
        bus_rdata[B_WKF]      = wkf_q;
        bus_rdata[B_IE]       = inten_q;
        bus_rdata[B_EN]       = en_eff;
        bus_rdata[B_TSL +: 3] = tsel_q;
        bus_rdata[B_BUSY]     = busy;
        bus_rdata[B_IGN]      = ign_q;
      end
      OFS_GRC: bus_rdata[1:0] = dsel_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              wdt_clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              unlock,
  input logic              force_en,
  input logic              wdt_rst_o,
  input logic              rst_p,
  input logic              tout_p,
  input logic              rstf_q,
  input logic              tof_q,
  input logic [1:0]        dsel_q,
  input logic              en_w,
  input logic [CNT_W-1:0]  cnt_w
);
  // R11: reset pulse is one system clock wide
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> !wdt_rst_o);

  // R4: reset event sets the flag and returns the grace select to 00
  a_r4_rst_side_effects: assert property (@(posedge clk) disable iff (!rst_n)
    rst_p |=> (rstf_q && dsel_q == 2'b00));

  // R2: the time-out flag only rises after a time-out event
  a_r2_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tof_q) |-> $past(tout_p));

  // R8: a locked write leaves the grace select alone
  a_r8_locked_grace: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !unlock && bus_addr == OFS_GRC && !rst_p) |=> $stable(dsel_q));

  // R9: forced enable always reads back as 1
  a_r9_force_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (force_en && bus_addr == OFS_CTL) |-> bus_rdata[B_EN]);

  // R6: a disabled watchdog holds its counter at zero
  a_r6_disable_clears: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    !en_w |=> (cnt_w == '0));
endmodule

bind wdt_top wdt_chk u_chk (
  .clk(clk), .wdt_clk(wdt_clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .unlock(unlock), .force_en(force_en), .wdt_rst_o(wdt_rst_o),
  .rst_p(rst_p), .tout_p(tout_p), .rstf_q(rstf_q), .tof_q(tof_q), .dsel_q(dsel_q),
  .en_w(en_w), .cnt_w(cnt_w)
);

// File: tb/wdt_top_bench.sv
`timescale 1ns/1ps
module wdt_top_bench;
  logic        clk = 1'b0;
  logic        wdt_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        unlock = 1'b0, force_en = 1'b0, dbg_halt = 1'b0;
  logic        irq, wake_req, wdt_rst_o;

  int n_chk = 0, n_bad = 0;
  int rst_seen = 0, rst_wide = 0, wclk_n = 0;
  logic rst_prev = 1'b0;

  localparam logic [31:0] C_EN = 32'h80, C_IE = 32'h40, C_WK = 32'h10, C_RE = 32'h2;
  localparam logic [31:0] C_IGN = 32'h8000_0000, C_KB = 32'h1;

  always #10 clk = ~clk;                 // 50 MHz
  initial begin #7; forever #50 wdt_clk = ~wdt_clk; end

  wdt_top u_wdt_top (
    .clk(clk), .wdt_clk(wdt_clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unlock(unlock), .force_en(force_en),
    .dbg_halt(dbg_halt), .irq(irq), .wake_req(wake_req), .wdt_rst_o(wdt_rst_o)
  );

  always @(posedge wdt_clk) wclk_n++;
  always @(negedge clk) begin
    if (wdt_rst_o) begin
      if (rst_prev) rst_wide++;
      else          rst_seen++;
    end
    rst_prev = wdt_rst_o;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [3:0] a, input logic [31:0] d, input logic u);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; unlock = u;
    @(negedge clk);
    bus_wr = 1'b0; unlock = 1'b0;
  endtask

  task automatic brd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_w(input int n);
    repeat (n) @(posedge wdt_clk);
    @(negedge clk);
  endtask

  // disable, let it settle, clear all sticky flags
  task automatic quiesce();
    bwr(4'h0, 32'h0, 1'b1);
    wait_w(8);
    bwr(4'h0, 32'h2C, 1'b0);
  endtask

  // watchdog clocks between interrupt rise and reset pulse
  task automatic grace_gap(output int gap);
    int t0, r0, lim;
    lim = 0;
    while (!irq && lim < 20000) begin @(negedge clk); lim++; end
    t0 = wclk_n; r0 = rst_seen;
    lim = 0;
    while (rst_seen == r0 && lim < 20000) begin @(negedge clk); lim++; end
    gap = wclk_n - t0;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int gap, r0;
    #95 rst_n = 1'b1;
    wait_w(2);

    // R1 reset image
    brd(4'h0, d); chk("R1 ctl", d, 32'h0);
    brd(4'h4, d); chk("R1 grace", d, 32'h0);
    brd(4'h8, d); chk("R1 key", d, 32'h0);
    brd(4'hC, d); chk("R1 undef", d, 32'h0);

    // R8 locked writes ignored
    bwr(4'h0, 32'hFFFF_FFFF, 1'b0);
    bwr(4'h4, 32'h3, 1'b0);
    brd(4'h0, d); chk("R8 locked ctl", d, 32'h0);
    brd(4'h4, d); chk("R8 locked grace", d, 32'h0);
    bwr(4'h4, 32'h2, 1'b1);
    brd(4'h4, d); chk("R8 unlocked grace", d, 32'h2);

    // R9 forced enable
    force_en = 1'b1;
    bwr(4'h0, 32'h0, 1'b1);
    brd(4'h0, d); chk("R9 force bit7", {31'b0, d[7]}, 32'h1);
    force_en = 1'b0;
    wait_w(8);
    brd(4'h0, d); chk("R9 release", d, 32'h0);

    // R2 / R6 time-out at sel 0 and busy flag
    bwr(4'h0, C_EN | C_IE, 1'b1);
    brd(4'h0, d); chk("R6 busy after enable", {31'b0, d[30]}, 32'h1);
    wait_w(12);
    chk("R2 no early irq", {31'b0, irq}, 32'h0);
    brd(4'h0, d); chk("R6 busy settled", {31'b0, d[30]}, 32'h0);
    wait_w(12);
    chk("R2 irq at interval", {31'b0, irq}, 32'h1);
    brd(4'h0, d); chk("R2 flag bit3", {31'b0, d[3]}, 32'h1);
    bwr(4'h0, 32'h0, 1'b1);
    wait_w(8);
    bwr(4'h0, 32'h8, 1'b0);
    brd(4'h0, d); chk("R4 w1c bit3", d, 32'h0);

    // R7 key kicks keep it quiet, wrong key does not
    bwr(4'h0, C_EN | C_IE | (32'h1 << 8), 1'b1);
    for (int i = 0; i < 5; i++) begin
      wait_w(30);
      bwr(4'h8, 32'h0000_5AA5, 1'b0);
    end
    chk("R7 key kicks hold off", {31'b0, irq}, 32'h0);
    wait_w(30);
    bwr(4'h8, 32'h0000_5AA4, 1'b0);
    wait_w(45);
    chk("R7 wrong key ignored", {31'b0, irq}, 32'h1);
    quiesce();

    // R7 kick bit
    bwr(4'h0, C_EN | C_IE | (32'h1 << 8), 1'b1);
    for (int i = 0; i < 4; i++) begin
      wait_w(30);
      bwr(4'h0, C_EN | C_IE | (32'h1 << 8) | C_KB, 1'b1);
    end
    chk("R7 kick bit holds off", {31'b0, irq}, 32'h0);
    brd(4'h0, d); chk("R7 kick bit reads 0", {31'b0, d[0]}, 32'h0);
    quiesce();

    // R6 disable clears the counter
    bwr(4'h0, C_EN | C_IE | (32'h1 << 8), 1'b1);
    wait_w(50);
    bwr(4'h0, C_IE | (32'h1 << 8), 1'b1);
    wait_w(8);
    bwr(4'h0, C_EN | C_IE | (32'h1 << 8), 1'b1);
    wait_w(50);
    chk("R6 counter restarted", {31'b0, irq}, 32'h0);
    wait_w(30);
    chk("R6 times out after restart", {31'b0, irq}, 32'h1);
    quiesce();

    // R10 debug halt
    dbg_halt = 1'b1;
    bwr(4'h0, C_EN | C_IE, 1'b1);
    wait_w(60);
    chk("R10 halted", {31'b0, irq}, 32'h0);
    bwr(4'h0, C_EN | C_IE | C_IGN, 1'b1);
    wait_w(30);
    chk("R10 ignore halt", {31'b0, irq}, 32'h1);
    dbg_halt = 1'b0;
    quiesce();

    // R5 wake-up
    bwr(4'h0, C_EN | C_IE | C_WK, 1'b1);
    wait_w(30);
    chk("R5 wake_req", {31'b0, wake_req}, 32'h1);
    brd(4'h0, d); chk("R5 flag bit5", {31'b0, d[5]}, 32'h1);
    quiesce();
    chk("R4 w1c bit5", {31'b0, wake_req}, 32'h0);

    // R3 / R4 / R11 grace windows
    bwr(4'h4, 32'h2, 1'b1);
    bwr(4'h0, C_EN | C_IE | C_RE, 1'b1);
    grace_gap(gap);
    chk("R3 grace 18", {31'b0, (gap >= 16 && gap <= 20)}, 32'h1);
    brd(4'h0, d); chk("R4 reset flag", {31'b0, d[2]}, 32'h1);
    brd(4'h4, d); chk("R4 grace back to 00", d, 32'h0);
    quiesce();
    brd(4'h0, d); chk("R4 w1c bit2", d, 32'h0);

    bwr(4'h4, 32'h3, 1'b1);
    bwr(4'h0, C_EN | C_IE | C_RE, 1'b1);
    grace_gap(gap);
    chk("R3 grace 3", {31'b0, (gap >= 1 && gap <= 5)}, 32'h1);
    quiesce();

    bwr(4'h0, C_EN | C_IE | C_RE, 1'b1);
    grace_gap(gap);
    chk("R3 grace 1026", {31'b0, (gap >= 1024 && gap <= 1028)}, 32'h1);
    quiesce();

    // R11 no reset without reset enable
    bwr(4'h4, 32'h3, 1'b1);
    r0 = rst_seen;
    bwr(4'h0, C_EN | C_IE, 1'b1);
    wait_w(80);
    chk("R11 no reset when disarmed", rst_seen - r0, 0);
    chk("R11 pulse width one", rst_wide, 0);
    quiesce();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule